// File: doc/BRIEF.md
# PCI Base Address Window Decoder

This block watches the contents of a PCI function's six base address registers, its expansion ROM register and its command word. From them it works out which address windows the function currently answers to. Each region has a fixed size, set at build time, that is a power of two or zero for an unimplemented slot. Each region also has a fixed space: I/O or memory, and the ROM slot is always memory. Whenever any of these registers is written, the block decodes every region again. It registers the outcome, so each region's valid flag and aligned base appear one clock after the write.

Alongside each window the block gives a one-cycle change pulse. The pulse is raised when a region's new mapping is not the one it held before. The surrounding address map uses this event to tear down the old window before it installs the new one. A region that was not decoded before and is still not decoded counts as unchanged, whatever its base bits say.

Sanity checks drop mappings that cannot be real. The block rejects a zero base, a range that ends at or below its start, an I/O range that reaches past the 64 KiB port space, a memory range that touches the last byte of the 32-bit space, and a ROM whose enable bit is clear.

Top module: `bar_window_decoder`

## Requirements
- R1: A region whose parameter size is 0 is never reported valid, whatever its register holds.
- R2: A valid region's base output equals its register value with the low log2(size) bits cleared; bits below the size are ignored.
- R3: An I/O region is valid only when command bit 0 is 1, the base is nonzero, base+size-1 is greater than the base, and base+size-1 is below 0x10000.
- R4: A memory BAR is valid only when command bit 1 is 1, the base is nonzero, base+size-1 does not wrap past 0xFFFFFFFF, and base+size-1 is not 0xFFFFFFFF.
- R5: The ROM region (index 6) follows R4 and additionally requires bit 0 of the ROM register to be 1.
- R6: Outputs take the decode of the inputs sampled on a clock edge with wr_en high, visible from that edge on; with wr_en low the valid and base outputs hold.
- R7: win_changed[i] is high for exactly the cycle after a write in which region i's mapping differs from its previous one (valid flag differs, or both valid with different bases); it is low otherwise, including after writes that leave the mapping unchanged.
- R8: While rst is high and after it, until the first write, all valid, base and changed outputs are 0.
- R9: BAR n is taken from bar_regs[32n+31:32n] and reported at output index n for n = 0..5; the ROM is reported at index 6, with its base in win_base[223:192].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | A BAR, ROM or command register was written; decode again |
| cmd_word | input | 16 | Command register; bit 0 enables I/O decode, bit 1 enables memory decode |
| bar_regs | input | 192 | Six 32-bit BAR values, BAR n at bits 32n+31:32n |
| rom_reg | input | 32 | Expansion ROM register; bit 0 is the ROM enable |
| win_valid | output | 7 | Per-region decoded flag, index 6 is the ROM |
| win_base | output | 224 | Per-region aligned base, region i at bits 32i+31:32i; meaningless when invalid |
| win_changed | output | 7 | One-cycle pulse: region mapping changed at the last write |

## Verification
The bench builds the block with the defaults. BAR0 is 256 bytes of I/O and BAR4 is 16 bytes of I/O. BAR1, BAR2 and BAR5 are memory of 4 KiB, 1 MiB and 16 bytes. BAR3 is unimplemented, and the ROM is 64 KiB. The small sizes let single register values land exactly on the 0xFFFF I/O ceiling and on the 0xFFFFFFFF memory top, and the empty BAR3 exercises the size-zero rule with arbitrary register contents. Writes that repeat a mapping, move one base, or flip one enable bit separate real change events from spurious ones.

// File: rtl/bar_map_pkg.sv
package bar_map_pkg;

    localparam int unsigned REG_W        = 32;
    localparam int unsigned CMD_W        = 16;
    localparam int unsigned CMD_IO_BIT   = 0;
    localparam int unsigned CMD_MEM_BIT  = 1;
    localparam int unsigned ROM_EN_BIT   = 0;
    localparam logic [REG_W-1:0] IO_SPACE_TOP = 32'h0001_0000;
    localparam logic [REG_W-1:0] ADDR_TOP     = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        SPACE_MEM = 2'd0,
        SPACE_IO  = 2'd1,
        SPACE_ROM = 2'd2
    } space_e;

    typedef struct packed {
        logic             valid;
        logic [REG_W-1:0] base;
    } window_t;

    // Decode one region from its raw register, its static size and the command word.
    function automatic window_t decode_window(
        input space_e           kind,
        input logic [REG_W-1:0] size,
        input logic [REG_W-1:0] raw,
        input logic [CMD_W-1:0] cmd
    );
        window_t          w;
        logic [REG_W-1:0] lo;
        logic [REG_W-1:0] hi;
        logic             sane;
        logic             enabled;
        lo   = raw & ~(size - 1'b1);
        hi   = lo + size - 1'b1;
        sane = (lo != '0) && (hi > lo);
        unique case (kind)
            SPACE_IO:  enabled = cmd[CMD_IO_BIT] && (hi < IO_SPACE_TOP);
            SPACE_ROM: enabled = cmd[CMD_MEM_BIT] && raw[ROM_EN_BIT] && (hi != ADDR_TOP);
            default:   enabled = cmd[CMD_MEM_BIT] && (hi != ADDR_TOP);
        endcase
        w.valid = (size != '0) && sane && enabled;
        w.base  = lo;
        return w;
    endfunction

    // Two mappings are the same when both are off, or both on at one base.
    function automatic logic window_differs(input window_t a, input window_t b);
        return (a.valid != b.valid) || (a.valid && (a.base != b.base));
    endfunction

endpackage

// File: rtl/region_decode.sv
module region_decode
    import bar_map_pkg::*;
#(
    parameter space_e           SPACE = SPACE_MEM,
    parameter logic [REG_W-1:0] SIZE  = 32'h0000_1000
) (
    input  logic [REG_W-1:0] raw,
    input  logic [CMD_W-1:0] cmd,
    output window_t          win
);

    generate
        if (SIZE == '0) begin : g_absent
            logic unused_ok;
            assign unused_ok = ^{raw, cmd};
            assign win = '0;
        end else begin : g_present
            assign win = decode_window(SPACE, SIZE, raw, cmd);
        end
    endgenerate

endmodule

// File: rtl/region_track.sv
module region_track
    import bar_map_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  window_t next_win,
    output window_t cur_win,
    output logic    changed
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_win <= '0;
            changed <= 1'b0;
        end else begin
            changed <= 1'b0;
            if (load) begin
                cur_win <= next_win;
                changed <= window_differs(cur_win, next_win);
            end
        end
    end

endmodule

// File: rtl/bar_window_decoder.sv
module bar_window_decoder
    import bar_map_pkg::*;
#(
    parameter int unsigned NUM_BARS = 6,
    parameter logic [(NUM_BARS+1)*32-1:0] REGION_SIZES = {
        32'h0001_0000,  // ROM
        32'h0000_0010,  // BAR5 memory
        32'h0000_0010,  // BAR4 I/O
        32'h0000_0000,  // BAR3 unimplemented
        32'h0010_0000,  // BAR2 memory
        32'h0000_1000,  // BAR1 memory
        32'h0000_0100   // BAR0 I/O
    },
    parameter logic [NUM_BARS-1:0] BAR_IS_IO = 6'b01_0001
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [CMD_W-1:0]               cmd_word,
    input  logic [NUM_BARS*REG_W-1:0]      bar_regs,
    input  logic [REG_W-1:0]               rom_reg,
    output logic [NUM_BARS:0]              win_valid,
    output logic [(NUM_BARS+1)*REG_W-1:0]  win_base,
    output logic [NUM_BARS:0]              win_changed
);

    localparam int unsigned NUM_REGIONS = NUM_BARS + 1;

    window_t next_win [NUM_REGIONS];
    window_t cur_win  [NUM_REGIONS];

    generate
        for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
            localparam logic [REG_W-1:0] SZ = REGION_SIZES[i*REG_W +: REG_W];
            if (i == NUM_BARS) begin : g_rom
                region_decode #(.SPACE(SPACE_ROM), .SIZE(SZ)) u_dec (
                    .raw(rom_reg), .cmd(cmd_word), .win(next_win[i])
                );
            end else if (BAR_IS_IO[i]) begin : g_io
                region_decode #(.SPACE(SPACE_IO), .SIZE(SZ)) u_dec (
                    .raw(bar_regs[i*REG_W +: REG_W]), .cmd(cmd_word), .win(next_win[i])
                );
            end else begin : g_mem
                region_decode #(.SPACE(SPACE_MEM), .SIZE(SZ)) u_dec (
                    .raw(bar_regs[i*REG_W +: REG_W]), .cmd(cmd_word), .win(next_win[i])
                );
            end

            region_track u_trk (
                .clk      (clk),
                .rst      (rst),
                .load     (wr_en),
                .next_win (next_win[i]),
                .cur_win  (cur_win[i]),
                .changed  (win_changed[i])
            );

            assign win_valid[i]                = cur_win[i].valid;
            assign win_base[i*REG_W +: REG_W]  = cur_win[i].base;
        end
    endgenerate

endmodule

// File: rtl/bar_window_checker.sv
module bar_window_checker
    import bar_map_pkg::*;
#(
    parameter int unsigned NUM_BARS = 6,
    parameter logic [(NUM_BARS+1)*32-1:0] REGION_SIZES = '0,
    parameter logic [NUM_BARS-1:0] BAR_IS_IO = '0
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           wr_en,
    input logic [CMD_W-1:0]               cmd_word,
    input logic [REG_W-1:0]               rom_reg,
    input logic [NUM_BARS:0]              win_valid,
    input logic [(NUM_BARS+1)*REG_W-1:0]  win_base,
    input logic [NUM_BARS:0]              win_changed
);

    // R6: without a write the mapping holds
    a_r6_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(win_valid) && $stable(win_base)));

    // R7: no change event without a write
    a_r7_quiet_without_write: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (win_changed == '0));

    // R5: ROM enable bit
    a_r5_rom_needs_enable: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rom_reg[ROM_EN_BIT]) |=> !win_valid[NUM_BARS]);

    generate
        for (genvar i = 0; i <= NUM_BARS; i++) begin : g_chk
            localparam logic [REG_W-1:0] SZ = REGION_SIZES[i*REG_W +: REG_W];
            localparam logic [REG_W:0]   SZ_M1 = {1'b0, SZ} - 33'd1;
            if (SZ == '0) begin : g_absent
                // R1
                a_r1_unimpl_never_valid: assert property (@(posedge clk) disable iff (rst)
                    !win_valid[i]);
            end else begin : g_present
                // R2
                a_r2_base_aligned: assert property (@(posedge clk) disable iff (rst)
                    win_valid[i] |-> ((win_base[i*REG_W +: REG_W] & SZ_M1[REG_W-1:0]) == '0));
                if (i < NUM_BARS && BAR_IS_IO[i]) begin : g_io
                    // R3
                    a_r3_io_needs_enable: assert property (@(posedge clk) disable iff (rst)
                        (wr_en && !cmd_word[CMD_IO_BIT]) |=> !win_valid[i]);
                    a_r3_io_in_port_space: assert property (@(posedge clk) disable iff (rst)
                        win_valid[i] |-> ((win_base[i*REG_W +: REG_W] != '0) &&
                            (({1'b0, win_base[i*REG_W +: REG_W]} + SZ_M1) < 33'h0_0001_0000)));
                end else begin : g_mem
                    // R4
                    a_r4_mem_needs_enable: assert property (@(posedge clk) disable iff (rst)
                        (wr_en && !cmd_word[CMD_MEM_BIT]) |=> !win_valid[i]);
                    a_r4_mem_below_top: assert property (@(posedge clk) disable iff (rst)
                        win_valid[i] |-> ((win_base[i*REG_W +: REG_W] != '0) &&
                            (({1'b0, win_base[i*REG_W +: REG_W]} + SZ_M1) < 33'h0_FFFF_FFFF)));
                end
            end
        end
    endgenerate

endmodule

bind bar_window_decoder bar_window_checker #(
    .NUM_BARS     (NUM_BARS),
    .REGION_SIZES (REGION_SIZES),
    .BAR_IS_IO    (BAR_IS_IO)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .cmd_word    (cmd_word),
    .rom_reg     (rom_reg),
    .win_valid   (win_valid),
    .win_base    (win_base),
    .win_changed (win_changed)
);

// File: tb/sim_bar_window_decoder.sv
module sim_bar_window_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int NB = 6;
    localparam int NR = 7;
    localparam logic [NR*32-1:0] SIZES = {
        32'h0001_0000, 32'h0000_0010, 32'h0000_0010, 32'h0000_0000,
        32'h0010_0000, 32'h0000_1000, 32'h0000_0100
    };
    localparam logic [NB-1:0] IOMASK = 6'b01_0001;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [15:0]       cmd_word = '0;
    logic [NB*32-1:0]  bar_regs = '0;
    logic [31:0]       rom_reg = '0;
    logic [NR-1:0]     win_valid;
    logic [NR*32-1:0]  win_base;
    logic [NR-1:0]     win_changed;

    bar_window_decoder #(.NUM_BARS(NB), .REGION_SIZES(SIZES), .BAR_IS_IO(IOMASK)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .cmd_word(cmd_word),
        .bar_regs(bar_regs), .rom_reg(rom_reg),
        .win_valid(win_valid), .win_base(win_base), .win_changed(win_changed)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cycle = 0;
    always @(posedge clk) cycle <= cycle + 1;

    int n_checks = 0;
    int n_fails  = 0;

    typedef struct {
        logic [NR-1:0] v;
        logic [31:0]   b [NR];
        logic [NR-1:0] ch;
        int            due;
        string         tag;
    } exp_t;

    exp_t q[$];
    exp_t e;
    logic [NR-1:0] mv = '0;
    logic [31:0]   mb [NR];
    logic [31:0]   nb [NB];

    function automatic logic [31:0] size_of(int i);
        return SIZES[i*32 +: 32];
    endfunction

    function automatic logic [31:0] raw_of(int i);
        return (i == NB) ? rom_reg : bar_regs[i*32 +: 32];
    endfunction

    function automatic logic model_valid(int i, logic [31:0] raw, logic [15:0] cmd);
        logic [31:0] s, lo;
        logic [32:0] hi;
        s = size_of(i);
        if (s == 0) return 1'b0;
        lo = raw - (raw % s);
        hi = {1'b0, lo} + {1'b0, s} - 33'd1;
        if (i < NB && IOMASK[i])
            return cmd[0] && lo != 0 && hi > {1'b0, lo} && hi < 33'h1_0000;
        return cmd[1] && lo != 0 && hi > {1'b0, lo} && hi < 33'h0_FFFF_FFFF &&
               (i != NB || raw[0]);
    endfunction

    task automatic drive_write(input logic [15:0] cmd, input logic [31:0] rom, input string tag);
        exp_t x;
        @(negedge clk);
        cmd_word = cmd;
        rom_reg  = rom;
        for (int i = 0; i < NB; i++) bar_regs[i*32 +: 32] = nb[i];
        wr_en = 1'b1;
        for (int i = 0; i < NR; i++) begin
            logic [31:0] r, lo;
            logic        v;
            r  = raw_of(i);
            lo = (size_of(i) == 0) ? 32'h0 : r - (r % size_of(i));
            v  = model_valid(i, r, cmd);
            x.ch[i] = (v != mv[i]) || (v && mv[i] && lo != mb[i]);
            x.v[i]  = v;
            x.b[i]  = lo;
            mv[i]   = v;
            mb[i]   = lo;
        end
        x.due = cycle + 1;
        x.tag = tag;
        q.push_back(x);
    endtask

    task automatic drive_idle(input logic [15:0] cmd, input logic [31:0] rom, input string tag);
        exp_t x;
        @(negedge clk);
        wr_en    = 1'b0;
        cmd_word = cmd;
        rom_reg  = rom;
        for (int i = 0; i < NB; i++) bar_regs[i*32 +: 32] = ~nb[i];
        for (int i = 0; i < NR; i++) begin
            x.v[i] = mv[i];
            x.b[i] = mb[i];
        end
        x.ch  = '0;
        x.due = cycle + 1;
        x.tag = tag;
        q.push_back(x);
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0 && q[0].due == cycle) begin
                e = q.pop_front();
                for (int i = 0; i < NR; i++) begin
                    logic ok;
                    ok = (win_valid[i] == e.v[i]) && (win_changed[i] == e.ch[i]) &&
                         (!e.v[i] || win_base[i*32 +: 32] == e.b[i]);
                    n_checks++;
                    if (!ok) begin
                        n_fails++;
                        $display("FAIL %s region %0d: got v=%0b ch=%0b base=%h, expected v=%0b ch=%0b base=%h",
                                 e.tag, i, win_valid[i], win_changed[i], win_base[i*32 +: 32],
                                 e.v[i], e.ch[i], e.b[i]);
                    end
                end
            end
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fails++;
        $display("FAIL watchdog: run did not finish, got timeout, expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        for (int i = 0; i < NR; i++) mb[i] = '0;
        for (int i = 0; i < NB; i++) nb[i] = '0;
        repeat (3) @(negedge clk);
        // R8: reset state, checked while rst is high
        n_checks++;
        if (win_valid != '0 || win_changed != '0 || win_base != '0) begin
            n_fails++;
            $display("FAIL R8 reset: got v=%b ch=%b, expected all zero", win_valid, win_changed);
        end
        rst = 1'b0;
        drive_idle(16'h0, 32'h0, "R8 after reset");

        // R3 R4: nothing decodes with both enables off
        nb = '{32'h0000_C001, 32'hFEB0_0000, 32'h8000_0008, 32'h1234_5678, 32'h0000_E0F1, 32'h0};
        drive_write(16'h0000, 32'hFEA0_0001, "R3 R4 enables off");
        // R1 R2 R9: enable both, several regions map
        drive_write(16'h0003, 32'hFEA0_0001, "R1 R2 R9 enable both");
        drive_idle(16'h0000, 32'h0, "R6 hold");
        drive_idle(16'h0003, 32'h0, "R6 hold again");
        // R7: same mapping again, no change
        drive_write(16'h0003, 32'hFEA0_0001, "R7 repeat write");
        // R7: move BAR1 only
        nb[1] = 32'hFEC0_0000;
        drive_write(16'h0003, 32'hFEA0_0001, "R7 move one base");
        // R2: low bits below size ignored
        nb[1] = 32'hFEC0_0FFF;
        drive_write(16'h0003, 32'hFEA0_FFFF, "R2 low bits ignored");
        // R5: ROM enable off
        drive_write(16'h0003, 32'hFEA0_0000, "R5 rom disabled");
        // R3: I/O enable off
        drive_write(16'h0002, 32'hFEA0_0001, "R3 io disabled");
        // R4: memory enable off
        drive_write(16'h0001, 32'hFEA0_0001, "R4 mem disabled");
        // R3: I/O ending exactly at 0xFFFF
        nb[0] = 32'h0000_FF01; nb[4] = 32'h0000_FFF1;
        drive_write(16'h0003, 32'hFEA0_0001, "R3 io at ceiling");
        // R3: I/O crossing 64K
        nb[0] = 32'h0001_0001; nb[4] = 32'h0000_0001;
        drive_write(16'h0003, 32'hFEA0_0001, "R3 io beyond ceiling and zero base");
        // R4 R5: memory touching 0xFFFFFFFF
        nb[5] = 32'hFFFF_FFF0; nb[2] = 32'hFFE0_0000;
        drive_write(16'h0003, 32'hFFFF_0001, "R4 R5 memory top");
        nb[5] = 32'hFFFF_FFE0;
        drive_write(16'h0003, 32'hFFFE_0001, "R4 R5 just below top");
        drive_idle(16'h0003, 32'h0, "R6 hold after top");

        lfsr = 32'hACE1_2468;
        for (int k = 0; k < 40; k++) begin
            logic [31:0] romv;
            for (int i = 0; i < NB; i++) begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                nb[i] = IOMASK[i] ? (lfsr & 32'h0001_FFFF) : lfsr;
            end
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            romv = lfsr;
            if (k % 3 == 2) drive_idle(lfsr[17:2], romv, "R6 random idle");
            else drive_write({14'h0, lfsr[5:4] | {1'b0, k[0]}}, romv, "R7 random write");
        end

        repeat (4) @(negedge clk);
        summary();
        $finish;
    end

endmodule